// File: doc/BRIEF.md
# Shared-Line Barrier Synchronizer

This block lets N participants meet at a barrier using a single shared open-drain line. Each participant has an agent. The agent holds the line low until its participant says it is ready. It then lets go of the line and watches it. A pull-up makes the line read high only after every agent has let go. All agents see that rising level in the same clock and each gives a one-cycle proceed pulse to its participant. Completion is detected only from the level of the shared line. No central counter gathers per-participant done bits.

Inside the block the line is modelled as the AND of every agent's release flag, which matches an open-drain net with a weak high default. Each agent passes the line through its own synchronizer before acting on it. After proceed, an agent pulls the line low again to arm the next round. It releases again only on a fresh rising edge of its ready input. A rising edge that arrives before the agent has re-armed is remembered and acted on once re-arming is done. The participant count N may be set from 2 to 16.

Top module: `wand_barrier`

## Requirements
- R1: While reset is held and on the first clock after it, every bit of pull_low_o is 1, line_o is 0 and proceed_o is all zeros.
- R2: A rising edge of ready_i[i] is ready_i[i] high at a clock where it was low at the clock before; a high level at the first clock after reset counts as one. When an armed agent samples a rising edge at clock edge e, pull_low_o[i] is 0 from edge e onward.
- R3: While any bit of pull_low_o is 1, line_o is 0, no matter what the other agents do.
- R4: line_o is 1 whenever every bit of pull_low_o is 0.
- R5: With the default two-stage synchronizer, if the last agent samples its rising edge at clock edge e, proceed_o is high for exactly the one cycle between edges e+2 and e+3.
- R6: All bits of proceed_o rise in the same cycle, and no bit rises while any participant has not yet given its rising edge for the current round.
- R7: In the cycle after an agent's proceed pulse, its pull_low_o bit is 1 again.
- R8: Holding ready_i[i] high after a round does not release agent i again. Only a new rising edge does, so the line stays low and proceed_o stays zero.
- R9: A rising edge sampled while agent i is released or re-arming is kept pending. The agent releases on its own once its synchronized line reads low again, with no further activity on ready_i[i].

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ready_i | input | N | Per-participant ready level; a rising edge enters the barrier |
| proceed_o | output | N | Per-participant one-cycle pulse when the barrier opens |
| pull_low_o | output | N | Per-agent open-drain enable: 1 means the agent pulls the line low |
| line_o | output | 1 | Resolved level of the shared line |

## Verification
The assertions check on every cycle the following properties:
- The line is low whenever any agent pulls it.
- The line is high once all agents have released it.
- Proceed is a lockstep one-cycle pulse followed by re-arming.
- A release only follows a rising edge of ready, or one kept pending.

Only the bench scenarios can show the rest:
- The exact latency from the last ready edge to proceed.
- The absence of early pulses across random arrival orders.
- That a held-high ready does not start a new round.
- That a pending edge is carried across the re-arm phase.

// File: rtl/wb_pkg.sv
package wb_pkg;
  typedef enum logic [1:0] {
    ST_ARMED    = 2'd0,
    ST_RELEASED = 2'd1,
    ST_REARM    = 2'd2
  } agent_st_e;
endpackage

// File: rtl/wb_sync.sv
module wb_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic d_i,
  output logic q_o
);
  logic [STAGES-1:0] sh_q;
  logic [STAGES-1:0] sh_n;

  always_comb begin
    sh_n = {sh_q[STAGES-2:0], d_i};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sh_q <= '0;
    end else begin
      sh_q <= sh_n;
    end
  end

  assign q_o = sh_q[STAGES-1];
endmodule

// File: rtl/wb_line_resolve.sv
module wb_line_resolve #(
  parameter int N = 4
) (
  input  logic [N-1:0] rel_i,
  output logic         line_o
);
  // Open-drain net: any agent that has not released forces 0,
  // otherwise the weak pull-up wins.
  logic [N:0] chain;
  assign chain[0] = 1'b1;
  for (genvar g = 0; g < N; g++) begin : g_wire
    assign chain[g+1] = chain[g] & rel_i[g];
  end
  assign line_o = chain[N];
endmodule

// File: rtl/wb_agent.sv
module wb_agent
  import wb_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic ready_i,
  input  logic line_i,
  output logic pull_low_o,
  output logic proceed_o
);
  agent_st_e state_q, state_n;
  logic      ready_q;
  logic      pend_q, pend_n, pend_en;
  logic      rise;
  logic      line_s;

  wb_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk   (clk),
    .rst_n (rst_n),
    .d_i   (line_i),
    .q_o   (line_s)
  );

  assign rise = ready_i & ~ready_q;

  always_comb begin
    state_n = state_q;
    pend_n  = pend_q | rise;
    case (state_q)
      ST_ARMED: begin
        if (pend_q || rise) begin
          state_n = ST_RELEASED;
          pend_n  = 1'b0;
        end
      end
      ST_RELEASED: begin
        if (line_s) state_n = ST_REARM;
      end
      ST_REARM: begin
        if (!line_s) state_n = ST_ARMED;
      end
      default: state_n = ST_ARMED;
    endcase
  end

  assign pend_en = (pend_n != pend_q);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_ARMED;
      ready_q <= 1'b0;
      pend_q  <= 1'b0;
    end else begin
      state_q <= state_n;
      ready_q <= ready_i;
      if (pend_en) pend_q <= pend_n;
    end
  end

  assign pull_low_o = (state_q != ST_RELEASED);
  assign proceed_o  = (state_q == ST_RELEASED) && line_s;

  AST_PULSE_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
    proceed_o |=> !proceed_o); // R5
  AST_REARM_AFTER_PROCEED: assert property (@(posedge clk) disable iff (!rst_n)
    proceed_o |=> pull_low_o); // R7
  AST_RELEASE_NEEDS_EDGE: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(pull_low_o) |-> $past(pend_q || rise)); // R8
endmodule

// File: rtl/wand_barrier.sv
module wand_barrier #(
  parameter int N           = 4,
  parameter int SYNC_STAGES = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [N-1:0] ready_i,
  output logic [N-1:0] proceed_o,
  output logic [N-1:0] pull_low_o,
  output logic         line_o
);
  logic [N-1:0] rel;

  for (genvar g = 0; g < N; g++) begin : g_agent
    wb_agent #(.SYNC_STAGES(SYNC_STAGES)) u_agent (
      .clk        (clk),
      .rst_n      (rst_n),
      .ready_i    (ready_i[g]),
      .line_i     (line_o),
      .pull_low_o (pull_low_o[g]),
      .proceed_o  (proceed_o[g])
    );
    assign rel[g] = ~pull_low_o[g];
  end

  wb_line_resolve #(.N(N)) u_line (
    .rel_i  (rel),
    .line_o (line_o)
  );

  AST_LINE_LOW_WHILE_PULLED: assert property (@(posedge clk) disable iff (!rst_n)
    (|pull_low_o) |-> !line_o); // R3
  AST_LINE_HIGH_ALL_FREE: assert property (@(posedge clk) disable iff (!rst_n)
    (pull_low_o == '0) |-> line_o); // R4
  AST_PROCEED_LOCKSTEP: assert property (@(posedge clk) disable iff (!rst_n)
    (|proceed_o) |-> (&proceed_o)); // R6
  AST_PROCEED_AFTER_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
    (|proceed_o) |-> $past(line_o, 2)); // R5
endmodule

// File: tb/wand_barrier_test.sv
`timescale 1ns/1ps
module wand_barrier_test;
  localparam int N = 4;
  localparam logic [N-1:0] ALL = '1;

  logic         clk;
  logic         rst_n;
  logic [N-1:0] ready;
  logic [N-1:0] proceed;
  logic [N-1:0] pull_low;
  logic         line;

  int checks = 0;
  int errors = 0;
  int cyc    = 0;

  wand_barrier #(.N(N), .SYNC_STAGES(2)) uut (
    .clk        (clk),
    .rst_n      (rst_n),
    .ready_i    (ready),
    .proceed_o  (proceed),
    .pull_low_o (pull_low),
    .line_o     (line)
  );

  initial clk = 1'b0;
  always #2 clk = ~clk;

  task automatic summary_and_end();
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  endtask

  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (cyc > 100000) begin
      errors = errors + 1;
      $display("FAIL watchdog: actual %0d cycles expected < 100000", cyc);
      summary_and_end();
    end
  end

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks = checks + 1;
    if (act !== exp) begin
      errors = errors + 1;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic step(input int n = 1);
    for (int k = 0; k < n; k++) @(negedge clk);
  endtask

  // Expected proceed vector in a random round: it fires three samples after the last ready drive.
  function automatic logic [N-1:0] exp_proceed(input int t, input int last);
    return (t == last + 2) ? ALL : '0;
  endfunction

  initial begin
    int seed;
    int dly [N];
    int last;
    int seen;
    logic bad;
    seed = $urandom(32'h5eed_0042);
    rst_n = 1'b0;
    ready = '0;
    step(3);
    chk("R1 pull_low in reset", 32'(pull_low), 32'(ALL));
    chk("R1 line in reset", 32'(line), 0);
    chk("R1 proceed in reset", 32'(proceed), 0);
    rst_n = 1'b1;
    step(1);
    chk("R1 pull_low after reset", 32'(pull_low), 32'(ALL));

    // Partial readiness: all but the last participant
    ready = {1'b0, {(N-1){1'b1}}};
    step(1);
    chk("R2 early agents release", 32'(pull_low), 32'(1 << (N-1)));
    bad = 1'b0;
    for (int k = 0; k < 8; k++) begin
      step(1);
      if (line !== 1'b0 || proceed !== '0) bad = 1'b1;
    end
    chk("R3 line stays low while one agent pulls", 32'(bad), 0);
    chk("R6 no proceed before last ready", 32'(proceed), 0);

    // Last participant arrives
    ready = ALL;
    step(1);
    chk("R4 line high when all released", 32'(line), 1);
    chk("R5 no proceed one sample after", 32'(proceed), 0);
    step(1);
    chk("R5 no proceed two samples after", 32'(proceed), 0);
    step(1);
    chk("R5 R6 proceed all at latency", 32'(proceed), 32'(ALL));
    step(1);
    chk("R5 proceed single cycle", 32'(proceed), 0);
    chk("R7 rearm pulls low", 32'(pull_low), 32'(ALL));

    // Held-high ready must not start a new round
    bad = 1'b0;
    for (int k = 0; k < 20; k++) begin
      step(1);
      if (proceed !== '0 || pull_low !== ALL || line !== 1'b0) bad = 1'b1;
    end
    chk("R8 held ready causes no release", 32'(bad), 0);

    // Pending edge carried over a round
    ready = '0;
    step(8);
    ready[0] = 1'b1;
    step(2);
    chk("R2 agent0 released", 32'(pull_low[0]), 0);
    ready[0] = 1'b0;
    step(1);
    ready[0] = 1'b1;
    step(1);
    ready = ALL;
    seen = 0;
    for (int k = 0; k < 8 && seen == 0; k++) begin
      step(1);
      if (proceed === ALL) seen = 1;
    end
    chk("R6 round with pending completes", 32'(seen), 1);
    bad = 1'b0;
    for (int k = 0; k < 12; k++) begin
      step(1);
      if (proceed !== '0) bad = 1'b1;
    end
    chk("R9 pending agent released on its own", 32'(pull_low), 32'(ALL & ~1));
    chk("R9 no proceed while others pull", 32'(bad), 0);

    // Close that round: others give fresh edges
    ready = 1;
    step(2);
    ready = ALL;
    seen = 0;
    for (int k = 0; k < 8 && seen == 0; k++) begin
      step(1);
      if (proceed === ALL) seen = 1;
    end
    chk("R6 closing round fires", 32'(seen), 1);
    ready = '0;
    step(8);

    // Random arrival orders
    for (int r = 0; r < 40; r++) begin
      last = 0;
      for (int i = 0; i < N; i++) begin
        dly[i] = $urandom_range(0, 15);
        if (dly[i] > last) last = dly[i];
      end
      bad = 1'b0;
      for (int t = 0; t <= last + 6; t++) begin
        for (int i = 0; i < N; i++) if (t >= dly[i]) ready[i] = 1'b1;
        step(1);
        if (proceed !== exp_proceed(t, last)) bad = 1'b1;
      end
      chk($sformatf("R5 R6 random round %0d", r), 32'(bad), 0);
      chk("R7 pull low after random round", 32'(pull_low), 32'(ALL));
      ready = '0;
      step(8);
    end

    summary_and_end();
  end
endmodule